// File: doc/BRIEF.md
# Display Window Write Sequencer

This block pushes a rectangular region of pixels into a display controller over a four-wire serial link, where a separate data/command line says whether each byte is an opcode or a parameter. A caller presents the first and last row, the first and last column, the source base address and the row stride of a frame buffer, then pulses a start strobe. The block sends three opcodes, each followed by its parameters: one that sets the row window, one that sets the column window, and one that opens the display memory for writing. It then streams the region row by row, reading the source through a byte-wide read port that returns data one cycle after the request.

Two pixel formats are supported. In greyscale mode each column unit is two source bytes, passed through unchanged. In colour mode each pixel is four source bytes. The first three are reduced to the colour depth the panel uses, and the fourth (alpha) is neither read nor sent. For a panel mounted upside down, a flip input in colour mode moves the row window down by the difference between the controller's row span and the panel height. A panel reset output runs a low-then-high timed sequence after block reset, and no transfer can begin until it completes.

Bytes go to an external shifter through a valid/ready handshake. The shifter must drop `tx_ready` in the cycle after it takes a byte and raise it again once that byte has been fully shifted out.

Top module: `disp_win_seq`

## Requirements
- R1: After `rst_n` is released, `panel_rst_n` is low for RST_LO_CYC clock cycles and then high. A start strobe is ignored until RST_HI_CYC further cycles have elapsed.
- R2: A transfer begins with seven bytes in this order: OP_ROW, first row, last row, OP_COL, first column, last column, OP_WR.
- R3: `dc` is 0 for every opcode byte taken by the shifter and 1 for every parameter or pixel byte.
- R4: `dc` does not change while `tx_ready` is low. A byte offered with `tx_valid` stays offered, with the same value, until it is taken.
- R5: In greyscale mode (`rgb_mode`=0) each row sends (last column − first column + 1) × 2 bytes, which are the source bytes at row address + 0, 1, 2, … passed through unchanged.
- R6: In colour mode (`rgb_mode`=1) each source pixel occupies 4 bytes. Bytes 0, 1 and 2 are sent shifted right by 8 − CH_BITS (2 by default), and byte 3 is never read. Each row therefore sends (last column − first column + 1) × 3 bytes.
- R7: With `flip`=1 in colour mode, both row bytes in the header carry FLIP_SPAN − PANEL_H added to them, modulo 256 (4 by default). In greyscale mode `flip` has no effect.
- R8: Rows are sent from the first row to the last row inclusive. The first row is read at `src_base`, and each later row starts `src_stride` bytes after the one before.
- R9: `done` is a single-cycle pulse, raised once per transfer after the shifter has returned to ready following the last pixel byte. `busy` falls in the next cycle.
- R10: A start strobe while `busy` is high is ignored. The running transfer keeps the parameters it latched and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe; latches all transfer parameters |
| rgb_mode | input | 1 | 0 = greyscale two bytes per column, 1 = colour from 4-byte pixels |
| flip | input | 1 | Shifts the row window in colour mode |
| row_first | input | 8 | First row of the window |
| row_last | input | 8 | Last row of the window (not below row_first) |
| col_first | input | 8 | First column of the window |
| col_last | input | 8 | Last column of the window (not below col_first) |
| src_base | input | AW | Source address of the first byte of the first row |
| src_stride | input | AW | Address step between rows |
| rd_en | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_byte | output | 8 | Byte value |
| tx_ready | input | 1 | Shifter idle and able to take a byte |
| dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |
| panel_rst_n | output | 1 | Active-low panel reset |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-transfer pulse |

## Verification
The bench models the shifter with a multi-cycle busy time and the frame buffer as a one-cycle-latency memory. It compares every byte and every `dc` level against a stream built by bench functions. The corner cases are the one-by-one window, where a design that ends rows early or late sends the wrong byte count, and colour pixels, where a design that fails to skip the alpha byte sends a fourth byte per pixel and makes extra reads. It also covers flip in both modes, where a design that applies the offset in greyscale corrupts the row bytes, and the command-to-parameter boundary, where a design that switches `dc` while the shifter is busy would be caught by the stability monitor. A second start issued mid-transfer shows whether the running transfer is restarted or corrupted. A start before the panel reset sequence ends shows whether the block begins too early.

// File: rtl/dws_pkg.sv
package dws_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_RD,
      ST_CAP,
      ST_SND,
      ST_FIN
   } dws_state_e;

   localparam int HDR_LEN = 7;

   // header slot holding an opcode (slots 0, 3, 6)
   function automatic logic hdr_is_op(input logic [2:0] idx);
      return (idx == 3'd0) || (idx == 3'd3) || (idx == 3'd6);
   endfunction
endpackage

// File: rtl/dws_rst_timer.sv
module dws_rst_timer #(
   parameter int LO_CYC = 5000,
   parameter int HI_CYC = 5000
) (
   input  logic clk,
   input  logic rst_n,
   output logic panel_rst_n,
   output logic ready
);
   localparam int LIM = LO_CYC + HI_CYC;
   localparam int CW  = $clog2(LIM + 1);
   localparam logic [CW-1:0] LIM_V = CW'(LIM);
   localparam logic [CW-1:0] LO_V  = CW'(LO_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q != LIM_V)
         cnt_q <= cnt_q + 1'b1;
   end

   assign panel_rst_n = (cnt_q >= LO_V);
   assign ready       = (cnt_q == LIM_V);
endmodule

// File: rtl/dws_addr_gen.sv
module dws_addr_gen #(
   parameter int AW = 16,
   parameter int SW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] stride,
   input  logic [8:0]    ncols,
   input  logic          rgb,
   input  logic          byte_adv,
   input  logic          row_adv,
   output logic [AW-1:0] addr,
   output logic          row_end
);
   logic [AW-1:0] row_base_q;
   logic [AW-1:0] stride_q;
   logic [SW-1:0] sidx_q;
   logic [SW-1:0] srclen_q;
   logic          rgb_q;
   logic [SW-1:0] step;

   // in colour mode the byte after channel 2 is alpha and is stepped over
   assign step    = (rgb_q && (sidx_q[1:0] == 2'd2)) ? SW'(2) : SW'(1);
   assign row_end = ((sidx_q + step) >= srclen_q);
   assign addr    = row_base_q + AW'(sidx_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_base_q <= '0;
         stride_q   <= '0;
         sidx_q     <= '0;
         srclen_q   <= '0;
         rgb_q      <= 1'b0;
      end else if (load) begin
         row_base_q <= base;
         stride_q   <= stride;
         sidx_q     <= '0;
         rgb_q      <= rgb;
         srclen_q   <= rgb ? (SW'(ncols) << 2) : (SW'(ncols) << 1);
      end else if (row_adv) begin
         row_base_q <= row_base_q + stride_q;
         sidx_q     <= '0;
      end else if (byte_adv) begin
         sidx_q <= sidx_q + step;
      end
   end
endmodule

// File: rtl/dws_pix_conv.sv
module dws_pix_conv #(
   parameter int CH_BITS = 6
) (
   input  logic       rgb,
   input  logic [7:0] din,
   output logic [7:0] dout
);
   generate
      if (CH_BITS == 8) begin : g_pass
         assign dout = din;
      end else begin : g_reduce
         localparam int SH = 8 - CH_BITS;
         assign dout = rgb ? (din >> SH) : din;
      end
   endgenerate
endmodule

// File: rtl/disp_win_seq.sv
module disp_win_seq #(
   parameter int         AW         = 16,
   parameter int         RST_LO_CYC = 5000,
   parameter int         RST_HI_CYC = 5000,
   parameter int         PANEL_H    = 128,
   parameter int         FLIP_SPAN  = 132,
   parameter int         CH_BITS    = 6,
   parameter logic [7:0] OP_ROW     = 8'h75,
   parameter logic [7:0] OP_COL     = 8'h15,
   parameter logic [7:0] OP_WR      = 8'h5C
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rgb_mode,
   input  logic          flip,
   input  logic [7:0]    row_first,
   input  logic [7:0]    row_last,
   input  logic [7:0]    col_first,
   input  logic [7:0]    col_last,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] src_stride,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [7:0]    rd_data,
   output logic          tx_valid,
   output logic [7:0]    tx_byte,
   input  logic          tx_ready,
   output logic          dc,
   output logic          panel_rst_n,
   output logic          busy,
   output logic          done
);
   import dws_pkg::*;

   localparam int         SW      = 11;
   localparam logic [7:0] ROW_OFS = 8'(FLIP_SPAN - PANEL_H);

   generate
      if (AW < SW) begin : g_bad_aw
         $error("AW must be at least 11");
      end
      if (CH_BITS < 1 || CH_BITS > 8) begin : g_bad_ch
         $error("CH_BITS must be 1..8");
      end
      if (FLIP_SPAN < PANEL_H) begin : g_bad_flip
         $error("FLIP_SPAN must not be below PANEL_H");
      end
      if (RST_LO_CYC < 1 || RST_HI_CYC < 1) begin : g_bad_rst
         $error("reset phases need at least one cycle");
      end
   endgenerate

   dws_state_e st_q;
   logic [2:0] hidx_q;
   logic [7:0] hr0_q, hr1_q, hc0_q, hc1_q;
   logic [7:0] rows_q, rowcnt_q;
   logic [7:0] pix_q;
   logic       rgb_q;
   logic       dc_q;

   logic       ready_pr;
   logic       accept;
   logic       want_dc;
   logic       presenting;
   logic       go;
   logic       row_end;
   logic       byte_adv, row_adv;
   logic [7:0] hdr_byte;
   logic [7:0] conv_byte;
   logic [7:0] ofs;
   logic [8:0] ncols;

   dws_rst_timer #(.LO_CYC(RST_LO_CYC), .HI_CYC(RST_HI_CYC)) u_rst (
      .clk         (clk),
      .rst_n       (rst_n),
      .panel_rst_n (panel_rst_n),
      .ready       (ready_pr)
   );

   assign ncols = {1'b0, col_last} - {1'b0, col_first} + 9'd1;
   assign go    = start && ready_pr && (st_q == ST_IDLE);

   dws_addr_gen #(.AW(AW), .SW(SW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go),
      .base     (src_base),
      .stride   (src_stride),
      .ncols    (ncols),
      .rgb      (rgb_mode),
      .byte_adv (byte_adv),
      .row_adv  (row_adv),
      .addr     (rd_addr),
      .row_end  (row_end)
   );

   dws_pix_conv #(.CH_BITS(CH_BITS)) u_conv (
      .rgb  (rgb_q),
      .din  (rd_data),
      .dout (conv_byte)
   );

   always_comb begin
      unique case (hidx_q)
         3'd0:    hdr_byte = OP_ROW;
         3'd1:    hdr_byte = hr0_q;
         3'd2:    hdr_byte = hr1_q;
         3'd3:    hdr_byte = OP_COL;
         3'd4:    hdr_byte = hc0_q;
         3'd5:    hdr_byte = hc1_q;
         default: hdr_byte = OP_WR;
      endcase
   end

   assign presenting = (st_q == ST_HDR) || (st_q == ST_SND);
   assign want_dc    = (st_q == ST_HDR) ? !hdr_is_op(hidx_q) : 1'b1;
   // a byte is only offered once the data/command line already matches it
   assign tx_valid   = presenting && (dc_q == want_dc);
   assign tx_byte    = (st_q == ST_HDR) ? hdr_byte : pix_q;
   assign accept     = tx_valid && tx_ready;
   assign dc         = dc_q;
   assign rd_en      = (st_q == ST_RD);
   assign busy       = (st_q != ST_IDLE);
   assign done       = (st_q == ST_FIN) && tx_ready;

   assign byte_adv = (st_q == ST_SND) && accept && !row_end;
   assign row_adv  = (st_q == ST_SND) && accept && row_end && (rowcnt_q != rows_q);
   assign ofs      = (rgb_mode && flip) ? ROW_OFS : 8'd0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dc_q <= 1'b1;
      else if (presenting && tx_ready)
         dc_q <= want_dc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         hidx_q   <= '0;
         hr0_q    <= '0;
         hr1_q    <= '0;
         hc0_q    <= '0;
         hc1_q    <= '0;
         rows_q   <= '0;
         rowcnt_q <= '0;
         pix_q    <= '0;
         rgb_q    <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (go) begin
               hidx_q   <= '0;
               hr0_q    <= row_first + ofs;
               hr1_q    <= row_last + ofs;
               hc0_q    <= col_first;
               hc1_q    <= col_last;
               rows_q   <= row_last - row_first;
               rowcnt_q <= '0;
               rgb_q    <= rgb_mode;
               st_q     <= ST_HDR;
            end
            ST_HDR: if (accept) begin
               if (hidx_q == 3'(HDR_LEN - 1))
                  st_q <= ST_RD;
               else
                  hidx_q <= hidx_q + 3'd1;
            end
            ST_RD:  st_q <= ST_CAP;
            ST_CAP: begin
               pix_q <= conv_byte;
               st_q  <= ST_SND;
            end
            ST_SND: if (accept) begin
               if (!row_end) begin
                  st_q <= ST_RD;
               end else if (rowcnt_q == rows_q) begin
                  st_q <= ST_FIN;
               end else begin
                  rowcnt_q <= rowcnt_q + 8'd1;
                  st_q     <= ST_RD;
               end
            end
            ST_FIN: if (tx_ready) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dws_chk.sv
module dws_chk #(
   parameter logic [7:0] OP_ROW = 8'h75,
   parameter logic [7:0] OP_COL = 8'h15,
   parameter logic [7:0] OP_WR  = 8'h5C
) (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_byte,
   input logic       dc,
   input logic       rd_en,
   input logic       panel_rst_n
);
   // R4
   dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ready |=> $stable(dc));

   // R4
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

   // R1
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !panel_rst_n |-> (!busy && !tx_valid && !rd_en));

   // R3
   cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !dc) |-> (tx_byte == OP_ROW || tx_byte == OP_COL || tx_byte == OP_WR));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tx_ready && !tx_valid));

   // R10
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R5
   read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (busy && !tx_valid));
endmodule

bind disp_win_seq dws_chk #(.OP_ROW(OP_ROW), .OP_COL(OP_COL), .OP_WR(OP_WR)) u_dws_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .tx_byte     (tx_byte),
   .dc          (dc),
   .rd_en       (rd_en),
   .panel_rst_n (panel_rst_n)
);

// File: tb/disp_win_seq_test.sv
module disp_win_seq_test;
   localparam int AW    = 12;
   localparam int LO    = 40;
   localparam int HI    = 30;
   localparam int SHIFT = 5;
   localparam int MAXB  = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          rgb_mode = 1'b0, flip = 1'b0;
   logic [7:0]    row_first = '0, row_last = '0, col_first = '0, col_last = '0;
   logic [AW-1:0] src_base = '0, src_stride = '0;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data = '0;
   logic          tx_valid;
   logic [7:0]    tx_byte;
   logic          tx_ready = 1'b1;
   logic          dc, panel_rst_n, busy, done;

   always #10 clk = ~clk;

   disp_win_seq #(.AW(AW), .RST_LO_CYC(LO), .RST_HI_CYC(HI)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .rgb_mode(rgb_mode), .flip(flip),
      .row_first(row_first), .row_last(row_last), .col_first(col_first),
      .col_last(col_last), .src_base(src_base), .src_stride(src_stride),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready), .dc(dc),
      .panel_rst_n(panel_rst_n), .busy(busy), .done(done)
   );

   logic [7:0] mem [0:4095];
   int checks = 0, errors = 0;
   int ncap = 0, nrd = 0, ndone = 0, dcbad = 0, sh_cnt = 0;
   logic [7:0] cap_b [0:MAXB-1];
   logic       cap_dc [0:MAXB-1];
   logic [7:0] exp_b [0:MAXB-1];
   logic       exp_dc [0:MAXB-1];
   int nexp = 0, npix_rd = 0;
   logic prev_ready = 1'b1, prev_dc = 1'b1;

   // frame buffer with one cycle read latency
   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   // shifter model: busy for SHIFT cycles after it takes a byte
   always @(posedge clk) begin
      if (tx_valid && tx_ready) begin
         tx_ready <= 1'b0;
         sh_cnt   <= SHIFT;
      end else if (!tx_ready) begin
         if (sh_cnt <= 1) tx_ready <= 1'b1;
         sh_cnt <= sh_cnt - 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready && ncap < MAXB) begin
            cap_b[ncap]  = tx_byte;
            cap_dc[ncap] = dc;
            ncap++;
         end
         if (rd_en) nrd++;
         if (done) ndone++;
         if (!prev_ready && dc !== prev_dc) dcbad++;
         prev_ready = tx_ready;
         prev_dc    = dc;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic build_exp(input bit rgb, input bit flp, input int r0, input int r1,
                            input int c0, input int c1, input int base, input int stride);
      int ofs, n;
      ofs = (rgb && flp) ? 4 : 0;
      n   = c1 - c0 + 1;
      nexp = 0;
      exp_b[0] = 8'h75; exp_b[1] = 8'((r0 + ofs) % 256); exp_b[2] = 8'((r1 + ofs) % 256);
      exp_b[3] = 8'h15; exp_b[4] = 8'(c0); exp_b[5] = 8'(c1); exp_b[6] = 8'h5C;
      exp_dc[0] = 0; exp_dc[1] = 1; exp_dc[2] = 1; exp_dc[3] = 0;
      exp_dc[4] = 1; exp_dc[5] = 1; exp_dc[6] = 0;
      nexp = 7;
      for (int r = 0; r <= r1 - r0; r++) begin
         if (rgb) begin
            for (int p = 0; p < n; p++)
               for (int ch = 0; ch < 3; ch++) begin
                  exp_b[nexp]  = mem[(base + r*stride + 4*p + ch) % 4096] >> 2;
                  exp_dc[nexp] = 1;
                  nexp++;
               end
         end else begin
            for (int k = 0; k < 2*n; k++) begin
               exp_b[nexp]  = mem[(base + r*stride + k) % 4096];
               exp_dc[nexp] = 1;
               nexp++;
            end
         end
      end
      npix_rd = (r1 - r0 + 1) * n * (rgb ? 3 : 2);
   endtask

   task automatic run_xfer(input bit rgb, input bit flp, input int r0, input int r1,
                           input int c0, input int c1, input int base, input int stride,
                           input bit poke);
      int t, hbad, pbad, dcb, fi;
      string preq;
      build_exp(rgb, flp, r0, r1, c0, c1, base, stride);
      @(negedge clk);
      ncap = 0; nrd = 0; ndone = 0;
      rgb_mode = rgb; flip = flp;
      row_first = 8'(r0); row_last = 8'(r1); col_first = 8'(c0); col_last = 8'(c1);
      src_base = AW'(base); src_stride = AW'(stride);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (12) @(negedge clk);
         rgb_mode = ~rgb; row_first = 8'd9; row_last = 8'd20; col_last = 8'd90;
         src_base = AW'(7);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (ndone == 0 && t < 20000) begin @(negedge clk); t++; end
      check(t < 20000, "R9", "transfer finished (cycles)", t, 20000);
      repeat (SHIFT + 12) @(negedge clk);
      check(ndone == 1, poke ? "R10" : "R9", "done pulses", ndone, 1);
      check(!busy, poke ? "R10" : "R9", "busy after done", busy, 0);
      check(ncap == nexp, "R8", "bytes sent", ncap, nexp);
      check(nrd == npix_rd, rgb ? "R6" : "R5", "source reads", nrd, npix_rd);
      hbad = -1; pbad = -1; dcb = -1;
      for (int i = 0; i < nexp && i < ncap; i++) begin
         if (cap_dc[i] !== exp_dc[i] && dcb < 0) dcb = i;
         if (cap_b[i] !== exp_b[i]) begin
            if (i < 7 && hbad < 0) hbad = i;
            if (i >= 7 && pbad < 0) pbad = i;
         end
      end
      fi = (hbad < 0) ? 0 : hbad;
      check(hbad < 0, flp ? "R7" : "R2", "header byte", cap_b[fi], exp_b[fi]);
      preq = rgb ? "R6" : "R5";
      fi = (pbad < 0) ? 7 : pbad;
      if (fi >= nexp) fi = nexp - 1;
      check(pbad < 0, preq, "pixel byte", cap_b[fi], exp_b[fi]);
      fi = (dcb < 0) ? 0 : dcb;
      check(dcb < 0, "R3", "dc level", cap_dc[fi], exp_dc[fi]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2024));
      for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      check(panel_rst_n == 0, "R1", "panel reset during rst_n", panel_rst_n, 0);
      check(!tx_valid && !busy && !done, "R1", "outputs idle in reset", tx_valid, 0);
      rst_n = 1'b1;
      repeat (LO - 1) @(negedge clk);
      check(panel_rst_n == 0, "R1", "panel reset low at end of low phase", panel_rst_n, 0);
      @(negedge clk);
      check(panel_rst_n == 1, "R1", "panel reset released", panel_rst_n, 1);
      repeat (HI - 3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      check(!busy && ncap == 0, "R1", "early start ignored", busy, 0);
      repeat (5) @(negedge clk);

      // directed corners
      run_xfer(0, 0, 10, 10, 5, 5, 100, 32, 0);   // single column unit, single row
      run_xfer(0, 1, 3, 5, 0, 3, 200, 40, 0);     // flip has no effect in greyscale (R7)
      run_xfer(1, 0, 0, 0, 2, 2, 300, 32, 0);     // one colour pixel (R6)
      run_xfer(1, 1, 10, 12, 0, 3, 500, 48, 0);   // flipped colour rows (R7)
      run_xfer(1, 1, 254, 255, 7, 8, 640, 20, 0); // row offset wraps (R7)
      run_xfer(0, 0, 1, 3, 4, 6, 900, 16, 1);     // start while busy (R10)
      // random transfers
      for (int n = 0; n < 10; n++) begin
         int r0, c0, rs, cs;
         r0 = $urandom % 200; rs = $urandom % 4;
         c0 = $urandom % 100; cs = $urandom % 4;
         run_xfer(1'($urandom), 1'($urandom), r0, r0 + rs, c0, c0 + cs,
                  $urandom % 1024, 16 + $urandom % 48, 0);
      end
      check(dcbad == 0, "R4", "dc changes while shifter busy", dcbad, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule